// File: doc/BRIEF.md
# Serial Flash Command Engine

This block lets a host processor run single commands on a serial configuration flash through a small window of byte registers. The host loads a 16-bit frame length, counted in serial clocks, and a transmit stream. The stream holds an opcode byte, three address bytes and up to 128 outgoing data bytes. A write to the trigger offset then starts the frame. The engine lowers chip select, toggles the serial clock exactly as many times as programmed, and shifts the stream out. At the same stream positions it stores the bits returned by the flash into a receive buffer that the host can read.

Every byte is sent least significant bit first. A host that needs most-significant-first order on the wire stores each opcode and address byte bit-reversed. The receive side uses the same position rule. Bit k of the frame lands in receive byte k/8, bit k%8. A status byte that follows an 8-clock opcode therefore appears in receive byte 1, and read data that follows a 32-clock header starts at receive byte 4. The host polls a busy register until the frame is done.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset, busy reads 0 at offset 0x01, chip select (active low) is high, the serial clock is low and every receive byte reads 0x00.
- R2: Writes at offset 0x00 and 0x08 set the high and low byte of the frame length. Writes at 0x10 + 8*j set transmit byte j, for j from 0 to 131: j=0 is the opcode, j=1..3 are the address high, middle and low bytes, and data byte i sits at 0x30 + 8*i.
- R3: A write of any value to offset 0x7F8 starts a frame. Offset 0x01 reads 0x01 while the frame runs and 0x00 otherwise.
- R4: Frame bit k, counted from 0, is bit k%8 of transmit byte k/8. Positions at or beyond 1056 send 0.
- R5: Chip select falls on the clock after the trigger, one system clock before the first serial clock rising edge. Each serial clock period lasts SCK_DIV system clocks, high for the first half. There are exactly N rising edges for a frame length N. Chip select rises and busy falls together with the last falling edge.
- R6: MOSI changes only at serial clock falling edges (or as chip select falls) and holds while the serial clock is high. MISO is sampled at each rising edge.
- R7: The bit sampled at frame position k is stored as bit k%8 of receive byte k/8, which reads at offset 0x18 + 8*j (j = 0..250). Positions at or beyond 2008 are discarded, and bits that a frame does not reach keep their previous values.
- R8: With a frame length of 0, a trigger raises busy for exactly one clock, produces no serial clock, and leaves chip select high.
- R9: A trigger write while busy is ignored; the running frame keeps its length and timing.
- R10: Writes to the length and transmit registers while busy are ignored, so the running frame and later frames see the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 11 | Register byte offset, for reads and writes |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| flash_sck | output | 1 | Serial clock, idle low |
| flash_cs_n | output | 1 | Chip select, active low |
| flash_mosi | output | 1 | Serial data to the flash |
| flash_miso | input | 1 | Serial data from the flash |

## Verification
The frames tried include write-enable (8 clocks), status read (16), ID read (40), a program frame with address and data bytes, and a longer data read. Together they show that opcode, address and data lanes line up in the stream and that returned bits land at the matching positions. A zero-length frame and a 2050-clock frame bound the sequencer: the first has no shifting at all, and the second runs past the ends of both the transmit and receive buffers, which shows that zero fill and capture discard happen exactly at the buffer limits. A frame that is hit with a second trigger and with register writes while it runs shows whether the locking holds. A final read of the whole receive window shows which bits each earlier frame left untouched.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    localparam int ADDR_W = 11;
    localparam int CNT_W  = 16;
    localparam int LANE_W = ADDR_W - 3;

    localparam logic [ADDR_W-1:0] OFS_LEN_HI = 11'h000;
    localparam logic [ADDR_W-1:0] OFS_BUSY   = 11'h001;
    localparam logic [ADDR_W-1:0] OFS_LEN_LO = 11'h008;
    localparam logic [ADDR_W-1:0] OFS_TRIG   = 11'h7F8;

    // first lane index (offset / 8) of the transmit and receive windows
    localparam logic [LANE_W-1:0] TX_LANE0 = 8'd2;
    localparam logic [LANE_W-1:0] RX_LANE0 = 8'd3;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LEAD,
        SEQ_SHIFT,
        SEQ_ZERO
    } seq_state_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } host_wr_t;

    function automatic logic on_lane(input logic [ADDR_W-1:0] a,
                                     input logic [LANE_W-1:0] lane0);
        return (a[2:0] == 3'b000) && (a[ADDR_W-1:3] >= lane0);
    endfunction

endpackage

// File: rtl/sfe_regfile.sv
module sfe_regfile
    import sfe_pkg::*;
#(
    parameter int TX_BYTES = 132
) (
    input  logic             clk,
    input  logic             rst,
    input  host_wr_t         wr,
    input  logic             lock,
    input  logic [CNT_W-1:0] fetch_idx,
    output logic [CNT_W-1:0] frame_len,
    output logic             trig,
    output logic             fetch_bit
);
    localparam int TX_IW = $clog2(TX_BYTES);
    localparam logic [LANE_W-1:0] TX_LANES = LANE_W'(TX_BYTES);
    localparam logic [CNT_W-1:0]  TX_LIM   = CNT_W'(TX_BYTES * 8);

    logic [7:0]        tx_q [TX_BYTES];
    logic [LANE_W-1:0] lane;
    logic              tx_hit;

    assign lane   = wr.addr[ADDR_W-1:3] - TX_LANE0;
    assign tx_hit = on_lane(wr.addr, TX_LANE0) && (lane < TX_LANES);
    assign trig   = wr.we && (wr.addr == OFS_TRIG) && !lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_len <= '0;
            for (int i = 0; i < TX_BYTES; i++) tx_q[i] <= '0;
        end else if (wr.we && !lock) begin
            if (wr.addr == OFS_LEN_HI)      frame_len[15:8] <= wr.data;
            else if (wr.addr == OFS_LEN_LO) frame_len[7:0]  <= wr.data;
            else if (tx_hit)                tx_q[lane[TX_IW-1:0]] <= wr.data;
        end
    end

    always_comb begin
        fetch_bit = 1'b0;
        if (fetch_idx < TX_LIM)
            fetch_bit = tx_q[fetch_idx[3 +: TX_IW]][fetch_idx[2:0]];
    end

    // R10
    len_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(frame_len));

endmodule

// File: rtl/sfe_sequencer.sv
module sfe_sequencer
    import sfe_pkg::*;
#(
    parameter int SCK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic [CNT_W-1:0] frame_len,
    input  logic             fetch_bit,
    output logic [CNT_W-1:0] fetch_idx,
    output logic             busy,
    output logic             cs_n,
    output logic             sck,
    output logic             mosi,
    output logic             cap_en,
    output logic [CNT_W-1:0] cap_idx
);
    localparam int HALF = SCK_DIV / 2;
    localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF - 1);

    seq_state_e       st;
    logic [HC_W-1:0]  hc;
    logic [CNT_W-1:0] bit_q;
    logic             last_bit;
    logic             half_end;

    assign last_bit  = (bit_q == frame_len - 1'b1);
    assign half_end  = (hc == HC_LAST);
    assign fetch_idx = (st == SEQ_IDLE) ? '0 : bit_q + 1'b1;
    assign cap_en    = (st == SEQ_LEAD) || (st == SEQ_SHIFT && half_end && !sck);
    assign cap_idx   = bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SEQ_IDLE;
            busy  <= 1'b0;
            cs_n  <= 1'b1;
            sck   <= 1'b0;
            mosi  <= 1'b0;
            hc    <= '0;
            bit_q <= '0;
        end else begin
            case (st)
                SEQ_IDLE: if (trig) begin
                    busy  <= 1'b1;
                    bit_q <= '0;
                    hc    <= '0;
                    if (frame_len == '0) begin
                        st <= SEQ_ZERO;
                    end else begin
                        st   <= SEQ_LEAD;
                        cs_n <= 1'b0;
                        mosi <= fetch_bit;
                    end
                end
                SEQ_ZERO: begin
                    busy <= 1'b0;
                    st   <= SEQ_IDLE;
                end
                SEQ_LEAD: begin
                    sck <= 1'b1;
                    hc  <= '0;
                    st  <= SEQ_SHIFT;
                end
                default: begin
                    if (half_end) begin
                        hc <= '0;
                        if (sck) begin
                            sck <= 1'b0;
                            if (last_bit) begin
                                cs_n <= 1'b1;
                                busy <= 1'b0;
                                st   <= SEQ_IDLE;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                                mosi  <= fetch_bit;
                            end
                        end else begin
                            sck <= 1'b1;
                        end
                    end else begin
                        hc <= hc + 1'b1;
                    end
                end
            endcase
        end
    end

    // R5
    sck_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        sck |-> !cs_n);

    // R5
    cap_range_chk: assert property (@(posedge clk) disable iff (rst)
        cap_en |-> (cap_idx < frame_len));

    // R6
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));

    // R8
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && frame_len == '0) |=> !busy);

    // R9
    trig_idle_chk: assert property (@(posedge clk) disable iff (rst)
        trig |-> !busy);

endmodule

// File: rtl/sfe_capture.sv
module sfe_capture
    import sfe_pkg::*;
#(
    parameter int RX_BYTES = 251
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [CNT_W-1:0]  cap_idx,
    input  logic              miso,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int RX_IW = $clog2(RX_BYTES);
    localparam logic [LANE_W-1:0] RX_LANES = LANE_W'(RX_BYTES);
    localparam logic [CNT_W-1:0]  RX_LIM   = CNT_W'(RX_BYTES * 8);

    logic [7:0]        rx_q [RX_BYTES];
    logic [LANE_W-1:0] lane;
    logic              rx_hit;

    assign lane   = rd_addr[ADDR_W-1:3] - RX_LANE0;
    assign rx_hit = on_lane(rd_addr, RX_LANE0) && (lane < RX_LANES);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RX_BYTES; i++) rx_q[i] <= '0;
        end else if (cap_en && (cap_idx < RX_LIM)) begin
            rx_q[cap_idx[3 +: RX_IW]][cap_idx[2:0]] <= miso;
        end
    end

    assign rd_data = rx_hit ? rx_q[lane[RX_IW-1:0]] : 8'h00;

endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
    import sfe_pkg::*;
#(
    parameter int SCK_DIV  = 4,
    parameter int TX_BYTES = 132,
    parameter int RX_BYTES = 251
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              flash_sck,
    output logic              flash_cs_n,
    output logic              flash_mosi,
    input  logic              flash_miso
);
    host_wr_t         wr;
    logic [CNT_W-1:0] frame_len;
    logic [CNT_W-1:0] fetch_idx;
    logic [CNT_W-1:0] cap_idx;
    logic             trig;
    logic             fetch_bit;
    logic             busy;
    logic             cap_en;
    logic [7:0]       rx_data;

    assign wr = '{we: host_we, addr: host_addr, data: host_wdata};

    sfe_regfile #(.TX_BYTES(TX_BYTES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .lock      (busy),
        .fetch_idx (fetch_idx),
        .frame_len (frame_len),
        .trig      (trig),
        .fetch_bit (fetch_bit)
    );

    sfe_sequencer #(.SCK_DIV(SCK_DIV)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .frame_len (frame_len),
        .fetch_bit (fetch_bit),
        .fetch_idx (fetch_idx),
        .busy      (busy),
        .cs_n      (flash_cs_n),
        .sck       (flash_sck),
        .mosi      (flash_mosi),
        .cap_en    (cap_en),
        .cap_idx   (cap_idx)
    );

    sfe_capture #(.RX_BYTES(RX_BYTES)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .cap_idx (cap_idx),
        .miso    (flash_miso),
        .rd_addr (host_addr),
        .rd_data (rx_data)
    );

    assign host_rdata = (host_addr == OFS_BUSY) ? {7'b0, busy} : rx_data;

endmodule

// File: tb/sim_sflash_cmd_engine.sv
module sim_sflash_cmd_engine;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;
    localparam int TXB  = 132;
    localparam int RXB  = 251;

    logic clk = 0;
    logic rst = 1;
    always #4 clk = ~clk;

    logic        we = 0;
    logic [10:0] addr = 0;
    logic [7:0]  wdata = 0;
    logic        miso = 0;
    wire  [7:0]  rdata;
    wire         sck, cs_n, mosi;

    sflash_cmd_engine #(.SCK_DIV(DIV), .TX_BYTES(TXB), .RX_BYTES(RXB)) u0 (
        .clk(clk), .rst(rst), .host_we(we), .host_addr(addr),
        .host_wdata(wdata), .host_rdata(rdata), .flash_sck(sck),
        .flash_cs_n(cs_n), .flash_mosi(mosi), .flash_miso(miso)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string cur_tag = "R1";
    int    seed    = 0;

    // ---------------- behavioural reference ----------------
    logic [7:0] m_tx [TXB];
    logic [7:0] m_rx [RXB];
    int m_len = 0, m_n = 0, m_e = 0, m_end = 0, m_seed = 0;
    bit m_busy = 0;

    function automatic bit resp_bit(int s, int i);
        return ((i * 13 + s * 7) % 11) < 5;
    endfunction

    function automatic bit tx_bit(int b);
        if (b >= TXB * 8) return 1'b0;
        return m_tx[b / 8][b % 8];
    endfunction

    always @(posedge clk) begin
        bit was;
        int lim;
        if (rst) begin
            foreach (m_tx[i]) m_tx[i] = 8'h00;
            foreach (m_rx[i]) m_rx[i] = 8'h00;
            m_len = 0; m_busy = 0; m_e = 0;
        end else begin
            was = m_busy;
            if (m_busy) begin
                m_e++;
                if (m_e >= m_end) begin
                    m_busy = 0;
                    lim = (m_n < RXB * 8) ? m_n : RXB * 8;
                    for (int k = 0; k < lim; k++) m_rx[k / 8][k % 8] = resp_bit(m_seed, k);
                end
            end
            if (we && !was) begin
                if (addr == 11'h7F8) begin
                    m_busy = 1; m_e = 0; m_n = m_len; m_seed = seed;
                    m_end = (m_len == 0) ? 1 : 1 + (m_len - 1) * DIV + HALF;
                end else if (addr == 11'h000) m_len = (int'(wdata) << 8) | (m_len & 255);
                else if (addr == 11'h008) m_len = (m_len & 65280) | int'(wdata);
                else if (addr >= 16 && addr % 8 == 0 && (addr - 16) / 8 < TXB)
                    m_tx[(addr - 16) / 8] = wdata;
            end
        end
    end

    // ---------------- flash responder ----------------
    int s_idx = 0;
    bit s_prev = 0;
    always @(negedge clk) begin
        if (cs_n) s_idx = 0;
        else if (s_prev && !sck) s_idx++;
        s_prev = sck;
        miso = resp_bit(seed, s_idx);
    end

    // ---------------- per-clock comparison ----------------
    always @(negedge clk) begin
        bit e_cs, e_sck, e_mosi;
        int p, b;
        if (!rst && !done) begin
            e_cs = 1; e_sck = 0; e_mosi = 0;
            if (m_busy && m_n > 0) begin
                e_cs = 0;
                if (m_e == 0) b = 0;
                else begin
                    p = (m_e - 1) % DIV;
                    b = (m_e - 1) / DIV;
                    e_sck = (p < HALF);
                    if (p >= HALF) b++;
                end
                e_mosi = tx_bit(b);
                n_tests++;
                if (mosi !== e_mosi) begin
                    n_fail++;
                    $display("FAIL R4/R6 [%s] mosi got %b exp %b at bit %0d", cur_tag, mosi, e_mosi, b);
                end
            end
            n_tests++;
            if (u0.flash_cs_n !== e_cs || sck !== e_sck) begin
                n_fail++;
                $display("FAIL R5 [%s] cs_n/sck got %b%b exp %b%b", cur_tag, cs_n, sck, e_cs, e_sck);
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic summary;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog [%s] got timeout exp completion", cur_tag);
            summary();
        end
    end

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1;
        @(negedge clk); we = 0;
    endtask

    task automatic rd_chk(input logic [10:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); addr = a; #1;
        n_tests++;
        if (rdata !== e) begin
            n_fail++;
            $display("FAIL %s addr %h got %h exp %h", tag, a, rdata, e);
        end
    endtask

    task automatic bit_chk(input bit got, input bit e, input string tag);
        n_tests++;
        if (got !== e) begin
            n_fail++;
            $display("FAIL %s got %b exp %b", tag, got, e);
        end
    endtask

    task automatic wait_idle;
        do @(negedge clk); while (m_busy);
    endtask

    task automatic busy_len(output int c);
        c = 0; addr = 11'h001; #1;
        while (rdata != 8'h00) begin c++; @(negedge clk); #1; end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1
        bit_chk(cs_n, 1'b1, "R1 cs_n after reset");
        bit_chk(sck, 1'b0, "R1 sck after reset");
        rd_chk(11'h001, 8'h00, "R1 busy after reset");
        rd_chk(11'h018, 8'h00, "R1 rx byte0 after reset");
        rd_chk(11'h7E8, 8'h00, "R1 rx byte250 after reset");

        // R2 R3 write-enable frame
        cur_tag = "R2 write-enable";
        wr(11'h000, 8'h00); wr(11'h008, 8'd8); wr(11'h010, 8'h60);
        seed = 1; wr(11'h7F8, 8'h5A);
        rd_chk(11'h001, 8'h01, "R3 busy during frame");
        wait_idle();
        rd_chk(11'h001, 8'h00, "R3 busy after frame");

        // R7 status read
        cur_tag = "R7 status";
        wr(11'h008, 8'd16); wr(11'h010, 8'hA0);
        seed = 2; wr(11'h7F8, 8'h00); wait_idle();
        rd_chk(11'h020, m_rx[1], "R7 status byte");

        // R7 ID read
        cur_tag = "R7 id";
        wr(11'h008, 8'd40); wr(11'h010, 8'hD5);
        seed = 3; wr(11'h7F8, 8'h00); wait_idle();
        rd_chk(11'h038, m_rx[4], "R7 id byte");

        // R2 R4 program with address and data lanes
        cur_tag = "R2 program";
        wr(11'h008, 8'd56); wr(11'h010, 8'h40);
        wr(11'h018, 8'h80); wr(11'h020, 8'h01); wr(11'h028, 8'hC3);
        wr(11'h030, 8'h11); wr(11'h038, 8'h22); wr(11'h040, 8'h33);
        seed = 4; wr(11'h7F8, 8'h00); wait_idle();
        for (int j = 4; j < 7; j++) rd_chk(11'(24 + 8 * j), m_rx[j], "R7 program echo");

        // R6 R7 data read
        cur_tag = "R6 read";
        wr(11'h008, 8'd96); wr(11'h010, 8'hC0);
        seed = 5; wr(11'h7F8, 8'h00); wait_idle();
        for (int j = 4; j < 12; j++) rd_chk(11'(24 + 8 * j), m_rx[j], "R7 read data");

        // R8 zero length
        cur_tag = "R8 zero";
        wr(11'h008, 8'd0);
        @(negedge clk); addr = 11'h7F8; we = 1;
        @(negedge clk); we = 0; addr = 11'h001; #1;
        bit_chk(rdata[0], 1'b1, "R8 busy first cycle");
        bit_chk(cs_n, 1'b1, "R8 cs_n stays high");
        @(negedge clk); #1;
        bit_chk(rdata[0], 1'b0, "R8 busy second cycle");

        // R9 R10 writes and trigger while busy
        cur_tag = "R9 R10 busy lock";
        wr(11'h008, 8'd16); wr(11'h010, 8'hA0);
        seed = 6; wr(11'h7F8, 8'h00);
        repeat (4) @(negedge clk);
        wr(11'h7F8, 8'h01); wr(11'h010, 8'hFF); wr(11'h000, 8'h01); wr(11'h008, 8'h00);
        wait_idle();
        seed = 7; wr(11'h7F8, 8'h00);
        busy_len(c);
        n_tests++;
        if (c != 1 + 15 * DIV + HALF) begin
            n_fail++;
            $display("FAIL R10 frame length after locked writes got %0d exp %0d", c, 1 + 15 * DIV + HALF);
        end
        wait_idle();

        // R4 R7 frame past both buffer ends
        cur_tag = "R4 R7 long";
        wr(11'h000, 8'h08); wr(11'h008, 8'h02);
        wr(11'h428, 8'hA5); wr(11'h420, 8'h3C);
        seed = 8; wr(11'h7F8, 8'h00); wait_idle();

        // R7 whole receive window
        for (int j = 0; j < RXB; j++) rd_chk(11'(24 + 8 * j), m_rx[j], "R7 final window");

        summary();
    end
endmodule